// File: doc/BRIEF.md
# Link-On Wake Notification Controller

This block sits in a physical-layer device and decides when the sleeping link-layer controller must be woken. When the link is not running, it drives a square wave on a shared wake pin. Two kinds of event can start the wave. The first is a link-on packet addressed to this node. The second is a set of already-decoded interrupt flags. A bus reset treats the two differently: it cancels a wake that a packet started, but it leaves a wake that an interrupt flag holds.

The same pin has a second use during hardware reset. While reset is asserted the output driver is off, and the pin level is sampled as the default bus-manager contender strap. The captured value is kept on a separate status output. After reset the driver is enabled, and the pin carries either a steady low or the wake wave.

Top module: `lkon_wake_ctrl`

## Requirements
- R1: While waking, `wake_o` repeats a period of 8 clock cycles: high for 4, then low for 4. The first cycle after the wake starts is always the first high cycle of a period.
- R2: `wake_o` is low whenever no wake is in progress. `wake_oe` is 0 while `rst_n` is low, and 1 from the first clock edge after `rst_n` goes high.
- R3: `contender_o` holds the `pin_i` level sampled at the last clock edge while `rst_n` was low (1 = contender, 0 = not contender).
- R4: The link counts as active only when `link_pwr_i` = 1 and `link_ctl_i` = 1. While the link is active, no wake starts, and a packet event that arrives then is discarded.
- R5: With the link inactive, a one-cycle `lkon_pkt_i` pulse is held as a pending request. The wave's first high cycle appears two clock edges after the cycle in which the pulse was applied.
- R6: Once started, a wake continues until the link becomes active. The output is low at the next clock edge, and the pending packet request is cleared.
- R7: A `bus_rst_i` pulse clears the pending packet request. If no interrupt condition holds, `wake_o` is low from the second clock edge after the pulse.
- R8: A `bus_rst_i` pulse has no effect on a wake held by an interrupt condition. The wave keeps toggling.
- R9: An interrupt condition is `port_evt_i` = 1, or any of `cfg_tmo_i`, `cbl_pwr_i`, `st_tmo_i` = 1 while `resume_en_i` = 1. With the link inactive, the first high cycle appears one clock edge after the condition is applied. The three gated flags have no effect while `resume_en_i` = 0.
- R10: An interrupt condition that is present while the link is active starts a wake at the first clock edge after the link becomes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| link_pwr_i | input | 1 | Link power status, 1 = powered |
| link_ctl_i | input | 1 | Link-control register bit |
| lkon_pkt_i | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset occurred |
| port_evt_i | input | 1 | Port-event interrupt flag |
| cfg_tmo_i | input | 1 | Configuration-timeout interrupt flag |
| cbl_pwr_i | input | 1 | Cable-power-status interrupt flag |
| st_tmo_i | input | 1 | State-timeout interrupt flag |
| resume_en_i | input | 1 | Resuming-port interrupt enable |
| pin_i | input | 1 | Level of the shared pin, sampled as the strap during reset |
| wake_o | output | 1 | Wake waveform driven onto the shared pin |
| wake_oe | output | 1 | Output enable for the shared pin |
| contender_o | output | 1 | Captured bus-manager contender strap |

## Verification
The assertions check, on every clock edge, the rules that can be read locally: the latch is cleared by a bus reset or by an active link, the latch is set by a packet while the link is inactive, the output is low when no wake is requested, the wave restarts in its high phase, the wave goes low after its fourth high cycle, and the output enable comes up after reset. The bench scenarios cover what only whole sequences can show. These are the full 8-cycle pattern, the strap value across two resets, the different effect of a bus reset on packet wakes and on interrupt wakes, the gating by the enable bit, and a wake that starts only once the link goes inactive while a flag is pending.

// File: rtl/lkon_pkg.sv
package lkon_pkg;
  // Default wave period in system clock cycles
  localparam int unsigned WAVE_PERIOD_DEF = 8;

  // Decoded interrupt flags feeding the wake decision
  typedef struct packed {
    logic port_evt;
    logic cfg_tmo;
    logic cbl_pwr;
    logic st_tmo;
  } irq_flags_t;

  localparam int unsigned N_GATED = 3;
endpackage

// File: rtl/lkon_req.sv
module lkon_req
  import lkon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_active_i,
  input  logic       pkt_evt_i,
  input  logic       bus_rst_i,
  input  irq_flags_t flags_i,
  input  logic       resume_en_i,
  output logic       wake_req_o
);
  logic             pkt_q, pkt_d, pkt_en;
  logic [N_GATED-1:0] gated_vec;
  logic             gated_any, irq_req;

  assign gated_vec = {flags_i.cfg_tmo, flags_i.cbl_pwr, flags_i.st_tmo};

  generate
    if (N_GATED > 0) begin : g_gated
      assign gated_any = |gated_vec;
    end else begin : g_none
      assign gated_any = 1'b0;
    end
  endgenerate

  assign irq_req = flags_i.port_evt | (resume_en_i & gated_any);

  // Sticky packet request: cleared by bus reset or active link
  always_comb begin
    pkt_en = 1'b0;
    pkt_d  = pkt_q;
    if (link_active_i || bus_rst_i) begin
      pkt_en = 1'b1;
      pkt_d  = 1'b0;
    end else if (pkt_evt_i) begin
      pkt_en = 1'b1;
      pkt_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= 1'b0;
    else if (pkt_en) pkt_q <= pkt_d;
  end

  assign wake_req_o = ~link_active_i & (pkt_q | irq_req);

  // R7
  bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !pkt_q);
  // R4
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_active_i |=> !pkt_q);
  // R5
  pkt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_evt_i && !bus_rst_i && !link_active_i) |=> pkt_q);
endmodule

// File: rtl/lkon_wave.sv
module lkon_wave #(
  parameter int unsigned PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic wave_o
);
  localparam int unsigned HALF = PERIOD / 2;
  localparam int unsigned CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, wave_q, wave_d;

  always_comb begin
    if (!active_i)          cnt_d = '0;
    else if (!run_q)        cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
    wave_d = active_i && (cnt_d < HALF_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= active_i;
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !wave_o);
  // R1
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !run_q) |=> wave_o);
  // R1
  half_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == HALF_C - 1'b1) |=> !wave_o);
endmodule

// File: rtl/lkon_strap.sv
module lkon_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic strap_o,
  output logic oe_o
);
  logic strap_q, oe_q;

  // Strap sampled on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= 1'b1;
  end

  assign strap_o = strap_q;
  assign oe_o    = oe_q;

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_o));
  // R2
  oe_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> oe_o);
endmodule

// File: rtl/lkon_wake_ctrl.sv
module lkon_wake_ctrl
  import lkon_pkg::*;
#(
  parameter int unsigned PERIOD = WAVE_PERIOD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_pwr_i,
  input  logic link_ctl_i,
  input  logic lkon_pkt_i,
  input  logic bus_rst_i,
  input  logic port_evt_i,
  input  logic cfg_tmo_i,
  input  logic cbl_pwr_i,
  input  logic st_tmo_i,
  input  logic resume_en_i,
  input  logic pin_i,
  output logic wake_o,
  output logic wake_oe,
  output logic contender_o
);
  irq_flags_t flags;
  logic       link_active, wake_req;

  assign flags       = '{port_evt: port_evt_i, cfg_tmo: cfg_tmo_i,
                         cbl_pwr: cbl_pwr_i, st_tmo: st_tmo_i};
  assign link_active = link_pwr_i & link_ctl_i;

  lkon_req u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_active_i(link_active),
    .pkt_evt_i    (lkon_pkt_i),
    .bus_rst_i    (bus_rst_i),
    .flags_i      (flags),
    .resume_en_i  (resume_en_i),
    .wake_req_o   (wake_req)
  );

  lkon_wave #(.PERIOD(PERIOD)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(wake_req),
    .wave_o  (wake_o)
  );

  lkon_strap u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .strap_o(contender_o),
    .oe_o   (wake_oe)
  );

  // R6
  link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_active |=> !wake_o);
endmodule

// File: tb/lkon_wake_ctrl_tb.sv
module lkon_wake_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_pwr_i = 1'b0, link_ctl_i = 1'b0, lkon_pkt_i = 1'b0, bus_rst_i = 1'b0;
  logic port_evt_i = 1'b0, cfg_tmo_i = 1'b0, cbl_pwr_i = 1'b0, st_tmo_i = 1'b0;
  logic resume_en_i = 1'b0, pin_i = 1'b0;
  logic wake_o, wake_oe, contender_o;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  lkon_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .link_pwr_i(link_pwr_i), .link_ctl_i(link_ctl_i),
    .lkon_pkt_i(lkon_pkt_i), .bus_rst_i(bus_rst_i), .port_evt_i(port_evt_i),
    .cfg_tmo_i(cfg_tmo_i), .cbl_pwr_i(cbl_pwr_i), .st_tmo_i(st_tmo_i),
    .resume_en_i(resume_en_i), .pin_i(pin_i), .wake_o(wake_o),
    .wake_oe(wake_oe), .contender_o(contender_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    link_pwr_i = 1'b1; link_ctl_i = 1'b1;
    port_evt_i = 0; cfg_tmo_i = 0; cbl_pwr_i = 0; st_tmo_i = 0; resume_en_i = 0;
    step(2);
  endtask

  // Present sample must be the first high cycle
  task automatic expect_wave(input string tag);
    for (int i = 0; i < 16; i++) begin
      chk(wake_o, (i % 8) < 4, tag);
      step();
    end
  endtask

  task automatic t_reset(input logic strap);
    rst_n = 1'b0; pin_i = strap;
    step(3);
    chk(wake_oe, 1'b0, "R2 oe off in reset");
    rst_n = 1'b1; pin_i = ~strap;
    step();
    chk(contender_o, strap, "R3 strap captured");
    chk(wake_oe, 1'b1, "R2 oe on after reset");
    chk(wake_o, 1'b0, "R2 idle low");
  endtask

  task automatic t_pkt_wake();
    link_pwr_i = 1'b0; link_ctl_i = 1'b1;
    step();
    lkon_pkt_i = 1'b1; step(); lkon_pkt_i = 1'b0;
    chk(wake_o, 1'b0, "R5 not yet high");
    step();
    expect_wave("R1 R5 packet wave");
    link_pwr_i = 1'b1;
    step();
    chk(wake_o, 1'b0, "R6 link active stops wake");
    link_pwr_i = 1'b0;
    step(3);
    chk(wake_o, 1'b0, "R6 packet request cleared");
    quiet();
  endtask

  task automatic t_pkt_ignored();
    lkon_pkt_i = 1'b1; step(); lkon_pkt_i = 1'b0;
    step(2);
    chk(wake_o, 1'b0, "R4 no wake while active");
    link_ctl_i = 1'b0;
    step(3);
    chk(wake_o, 1'b0, "R4 packet discarded while active");
    quiet();
  endtask

  task automatic t_bus_rst_pkt();
    link_pwr_i = 1'b0;
    lkon_pkt_i = 1'b1; step(); lkon_pkt_i = 1'b0;
    step(3);
    chk(wake_o, 1'b1, "R5 wake started");
    bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
    step();
    for (int i = 0; i < 6; i++) begin
      chk(wake_o, 1'b0, "R7 bus reset cancels packet wake");
      step();
    end
    quiet();
  endtask

  task automatic t_bus_rst_irq();
    int highs = 0;
    link_pwr_i = 1'b0; port_evt_i = 1'b1;
    step(3);
    bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      highs += int'(wake_o);
      step();
    end
    checks++;
    if (highs != 4) begin
      errors++;
      $display("FAIL R8 highs after bus reset: actual=%0d expected=4", highs);
    end
    quiet();
  endtask

  task automatic t_gating();
    link_ctl_i = 1'b0; cfg_tmo_i = 1'b1; resume_en_i = 1'b0;
    step(6);
    chk(wake_o, 1'b0, "R9 gated flag without enable");
    resume_en_i = 1'b1;
    step();
    expect_wave("R9 R1 enabled flag wave");
    quiet();
    link_ctl_i = 1'b0; resume_en_i = 1'b1; st_tmo_i = 1'b1;
    step();
    chk(wake_o, 1'b1, "R9 state timeout flag");
    quiet();
    link_ctl_i = 1'b0; resume_en_i = 1'b1; cbl_pwr_i = 1'b1;
    step();
    chk(wake_o, 1'b1, "R9 cable power flag");
    quiet();
  endtask

  task automatic t_rearm();
    port_evt_i = 1'b1;
    step(4);
    chk(wake_o, 1'b0, "R10 pending while active");
    link_pwr_i = 1'b0;
    step();
    expect_wave("R10 R1 rearm on link inactive");
    quiet();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset(1'b1);
    quiet();
    t_pkt_wake();
    t_pkt_ignored();
    t_bus_rst_pkt();
    t_bus_rst_irq();
    t_gating();
    t_rearm();
    t_reset(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule